// File: doc/BRIEF.md
# Abstract register-access instruction generator

This block turns an abstract register-access debug command into the short run of 32-bit RISC-V instructions that a halted hart executes from the debug ROM. A command carries a register number, an access size, and transfer, write and post-execute flags. The block decodes which register class the number selects. For a write it builds a load from the debug data area into the register, and for a read it builds a store from the register into that area. It places the words in an abstract-command buffer and then raises the go flag of the selected hart.

Control and status registers are not reached by a direct load or store. They use a four-word sequence that parks s0 in the debug scratch CSR, moves the value through s0, and then restores s0. This path exists only when the program buffer is smaller than two words. With a larger buffer the debugger is expected to build the CSR access itself. The last word of every sequence is either EBREAK or, when post-execute is set, a relative jump into the program buffer. The hart clears its own go flag through `hart_done_i` when it has finished. While any go flag is set, the block refuses new commands.

Top module: `abs_reg_cmd_gen`

## Requirements
- R1: After reset all go flags are 0, the error code is 0 and every buffer word is 0.
- R2: Register numbers 0x1000..0x101F select integer register regno[4:0]. A write emits one load into that register (LW, funct3 010, for size 2; LD, funct3 011, for size 3). A read emits one store (SW or SD). The base register is x0 and the immediate is DATA_BASE. The words use opcode 0x03 for the load and 0x23 for the store.
- R3: Register numbers 0x1020..0x103F select floating-point register regno[4:0]. They use the FP load and store forms FLW, FLD, FSW and FSD (opcodes 0x07 and 0x27), with the same addressing as R2.
- R4: A register number below 0x1000 with progbuf_words_i < 2 emits four words. Word 0 is CSRRW x0,0x7B2,s0. A write continues with a load of s0 from DATA_BASE and then CSRRW x0,regno,s0. A read continues with CSRRS s0,regno,x0 and then a store of s0 to DATA_BASE. Word 3 is CSRRS s0,0x7B2,x0.
- R5: A CSR number with progbuf_words_i >= 2, or any register number of 0x1040 or above, gives error code 2 (not supported). In that case no go flag rises and the buffer is unchanged.
- R6: With transfer set, any size other than 2 or 3 gives error code 2, with no go flag and no buffer change.
- R7: The word after the access words has index n. Without post-execute it is EBREAK (0x00100073). With post-execute it is JAL x0 with offset 4*ABS_WORDS - 4*n.
- R8: With transfer clear, the register number and size are ignored, and only the final word of R7 is emitted, at index 0.
- R9: An accepted command sets go_o[hartsel_i] one cycle later and writes the error code 0. Pulsing hart_done_i[h] clears go_o[h].
- R10: A command that arrives while any go flag is set is refused. It writes error code 1, and it leaves the buffer and the go flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | One-cycle strobe carrying a command |
| transfer_i | input | 1 | Perform the register transfer |
| write_i | input | 1 | 1: data area to register; 0: register to data area |
| postexec_i | input | 1 | Jump into the program buffer after the access |
| size_i | input | 3 | Access size code (2 = 32-bit, 3 = 64-bit) |
| regno_i | input | 16 | Abstract register number |
| hartsel_i | input | HART_W (2) | Hart that receives the go flag |
| progbuf_words_i | input | PB_W (5) | Program buffer size in words |
| hart_done_i | input | NHARTS (4) | Per-hart completion pulse, clears go |
| abs_buf_o | output | ABS_WORDS×32 (160) | Abstract-command instruction buffer |
| go_o | output | NHARTS (4) | Per-hart go flags |
| cmderr_o | output | 3 | Result of the last command: 0 ok, 1 busy, 2 not supported |

## Verification
The hardest case to reach is refusal while busy. The bench leaves a hart's go flag set by withholding its completion pulse, issues a second command, and then checks that the buffer snapshot and the go flags survive. The CSR sequence is only reachable with a small program buffer, so the bench drives progbuf_words_i per command: 0 and 1 for the four-word path, and 2 for the not-supported result. The jump offsets at index 0, 1 and 4 come from commands with transfer clear, with a direct register, and with a CSR.

// File: rtl/abs_cmd_pkg.sv
package abs_cmd_pkg;
  typedef enum logic [2:0] {
    KIND_NONE, KIND_GPR, KIND_FPR, KIND_CSR, KIND_BAD
  } reg_kind_e;

  localparam logic [2:0]  ERR_NONE    = 3'd0;
  localparam logic [2:0]  ERR_BUSY    = 3'd1;
  localparam logic [2:0]  ERR_NOTSUP  = 3'd2;
  localparam logic [11:0] CSR_SCRATCH = 12'h7b2;
  localparam logic [4:0]  REG_S0      = 5'd8;
  localparam logic [4:0]  REG_ZERO    = 5'd0;
  localparam logic [6:0]  OPC_LOAD    = 7'h03;
  localparam logic [6:0]  OPC_STORE   = 7'h23;
  localparam logic [6:0]  OPC_FLOAD   = 7'h07;
  localparam logic [6:0]  OPC_FSTORE  = 7'h27;
  localparam logic [6:0]  OPC_SYSTEM  = 7'h73;
  localparam logic [6:0]  OPC_JAL     = 7'h6f;
  localparam logic [2:0]  F3_CSRRW    = 3'b001;
  localparam logic [2:0]  F3_CSRRS    = 3'b010;
  localparam logic [31:0] INSN_EBREAK = 32'h0010_0073;

  function automatic logic [31:0] enc_itype(logic [11:0] imm, logic [4:0] rs1,
                                            logic [2:0] f3, logic [4:0] rd,
                                            logic [6:0] opc);
    return {imm, rs1, f3, rd, opc};
  endfunction

  function automatic logic [31:0] enc_stype(logic [11:0] imm, logic [4:0] rs2,
                                            logic [4:0] rs1, logic [2:0] f3,
                                            logic [6:0] opc);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], opc};
  endfunction

  function automatic logic [31:0] enc_jal_x0(logic [20:0] off);
    return {off[20], off[10:1], off[11], off[19:12], REG_ZERO, OPC_JAL};
  endfunction
endpackage

// File: rtl/abs_reg_decode.sv
module abs_reg_decode
  import abs_cmd_pkg::*;
#(
  parameter int PB_W = 5
) (
  input  logic            transfer_i,
  input  logic [2:0]      size_i,
  input  logic [15:0]     regno_i,
  input  logic [PB_W-1:0] progbuf_words_i,
  output reg_kind_e       kind_o,
  output logic [4:0]      idx_o,
  output logic            wide_o,
  output logic            err_o
);
  logic size_ok;

  assign size_ok = (size_i == 3'd2) || (size_i == 3'd3);
  assign wide_o  = (size_i == 3'd3);
  assign idx_o   = regno_i[4:0];

  always_comb begin
    if (!transfer_i)                        kind_o = KIND_NONE;
    else if (regno_i < 16'h1000)            kind_o = (progbuf_words_i < PB_W'(2)) ? KIND_CSR : KIND_BAD;
    else if (regno_i < 16'h1020)            kind_o = KIND_GPR;
    else if (regno_i < 16'h1040)            kind_o = KIND_FPR;
    else                                    kind_o = KIND_BAD;
  end

  assign err_o = (kind_o == KIND_BAD) || ((kind_o != KIND_NONE) && !size_ok);
endmodule

// File: rtl/abs_seq_build.sv
module abs_seq_build
  import abs_cmd_pkg::*;
#(
  parameter int          ABS_WORDS = 5,
  parameter logic [11:0] DATA_BASE = 12'h380,
  localparam int         IDX_W     = $clog2(ABS_WORDS)
) (
  input  reg_kind_e                    kind_i,
  input  logic [4:0]                   idx_i,
  input  logic                         write_i,
  input  logic                         wide_i,
  input  logic                         postexec_i,
  input  logic [11:0]                  csr_i,
  output logic [ABS_WORDS-1:0][31:0]   words_o,
  output logic [IDX_W-1:0]             last_o
);
  logic [2:0]  f3_mem;
  logic [20:0] jal_off;
  logic [31:0] ld_s0, st_s0;

  assign f3_mem = {2'b01, wide_i};
  assign ld_s0  = enc_itype(DATA_BASE, REG_ZERO, f3_mem, REG_S0, OPC_LOAD);
  assign st_s0  = enc_stype(DATA_BASE, REG_S0, REG_ZERO, f3_mem, OPC_STORE);

  always_comb begin
    words_o = '0;
    last_o  = '0;
    unique case (kind_i)
      KIND_GPR: begin
        words_o[0] = write_i ? enc_itype(DATA_BASE, REG_ZERO, f3_mem, idx_i, OPC_LOAD)
                             : enc_stype(DATA_BASE, idx_i, REG_ZERO, f3_mem, OPC_STORE);
        last_o = IDX_W'(1);
      end
      KIND_FPR: begin
        words_o[0] = write_i ? enc_itype(DATA_BASE, REG_ZERO, f3_mem, idx_i, OPC_FLOAD)
                             : enc_stype(DATA_BASE, idx_i, REG_ZERO, f3_mem, OPC_FSTORE);
        last_o = IDX_W'(1);
      end
      KIND_CSR: begin
        words_o[0] = enc_itype(CSR_SCRATCH, REG_S0, F3_CSRRW, REG_ZERO, OPC_SYSTEM);
        if (write_i) begin
          words_o[1] = ld_s0;
          words_o[2] = enc_itype(csr_i, REG_S0, F3_CSRRW, REG_ZERO, OPC_SYSTEM);
        end else begin
          words_o[1] = enc_itype(csr_i, REG_ZERO, F3_CSRRS, REG_S0, OPC_SYSTEM);
          words_o[2] = st_s0;
        end
        words_o[3] = enc_itype(CSR_SCRATCH, REG_ZERO, F3_CSRRS, REG_S0, OPC_SYSTEM);
        last_o = IDX_W'(4);
      end
      default: last_o = '0;
    endcase
    jal_off = 21'(4 * ABS_WORDS) - 21'({last_o, 2'b00});
    words_o[last_o] = postexec_i ? enc_jal_x0(jal_off) : INSN_EBREAK;
  end
endmodule

// File: rtl/abs_hart_go.sv
module abs_hart_go #(
  parameter int  NHARTS = 4,
  localparam int HART_W = $clog2(NHARTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [HART_W-1:0] sel_i,
  input  logic [NHARTS-1:0] done_i,
  output logic [NHARTS-1:0] go_o,
  output logic              busy_o
);
  logic [NHARTS-1:0] set_vec;

  assign set_vec = set_i ? (NHARTS'(1) << sel_i) : '0;
  assign busy_o  = |go_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) go_o <= '0;
    else         go_o <= (go_o & ~done_i) | set_vec;
  end

  AST_GO_RISE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(go_o & ~$past(go_o))); // R9
  AST_GO_RISE_NEEDS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((go_o & ~$past(go_o)) != '0) |-> $past(set_i)); // R9
endmodule

// File: rtl/abs_reg_cmd_gen.sv
module abs_reg_cmd_gen
  import abs_cmd_pkg::*;
#(
  parameter int          NHARTS    = 4,
  parameter int          HART_W    = $clog2(NHARTS),
  parameter int          ABS_WORDS = 5,
  parameter int          PB_W      = 5,
  parameter logic [11:0] DATA_BASE = 12'h380
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cmd_valid_i,
  input  logic                       transfer_i,
  input  logic                       write_i,
  input  logic                       postexec_i,
  input  logic [2:0]                 size_i,
  input  logic [15:0]                regno_i,
  input  logic [HART_W-1:0]          hartsel_i,
  input  logic [PB_W-1:0]            progbuf_words_i,
  input  logic [NHARTS-1:0]          hart_done_i,
  output logic [ABS_WORDS-1:0][31:0] abs_buf_o,
  output logic [NHARTS-1:0]          go_o,
  output logic [2:0]                 cmderr_o
);
  localparam int IDX_W = $clog2(ABS_WORDS);

  reg_kind_e                  kind;
  logic [4:0]                 idx;
  logic                       wide, dec_err, busy, accept;
  logic [ABS_WORDS-1:0][31:0] words;
  logic [IDX_W-1:0]           last;

  abs_reg_decode #(.PB_W(PB_W)) u_dec (
    .transfer_i, .size_i, .regno_i, .progbuf_words_i,
    .kind_o(kind), .idx_o(idx), .wide_o(wide), .err_o(dec_err)
  );

  abs_seq_build #(.ABS_WORDS(ABS_WORDS), .DATA_BASE(DATA_BASE)) u_seq (
    .kind_i(kind), .idx_i(idx), .write_i, .wide_i(wide), .postexec_i,
    .csr_i(regno_i[11:0]), .words_o(words), .last_o(last)
  );

  assign accept = cmd_valid_i && !busy && !dec_err;

  abs_hart_go #(.NHARTS(NHARTS)) u_go (
    .clk_i, .rst_ni, .set_i(accept), .sel_i(hartsel_i),
    .done_i(hart_done_i), .go_o, .busy_o(busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      abs_buf_o <= '0;
      cmderr_o  <= ERR_NONE;
    end else if (cmd_valid_i) begin
      if (busy)         cmderr_o <= ERR_BUSY;
      else if (dec_err) cmderr_o <= ERR_NOTSUP;
      else begin
        cmderr_o <= ERR_NONE;
        for (int k = 0; k < ABS_WORDS; k++)
          if (k <= int'(last)) abs_buf_o[k] <= words[k];
      end
    end
  end

  AST_BUSY_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && busy) |=> (cmderr_o == ERR_BUSY) && $stable(abs_buf_o)); // R10
  AST_NOTSUP_NO_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy && dec_err) |=> (cmderr_o == ERR_NOTSUP) && $stable(abs_buf_o)); // R5
  AST_OK_SETS_GO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (cmderr_o == ERR_NONE) && go_o[$past(hartsel_i)]); // R9
  AST_FINAL_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !postexec_i) |=> abs_buf_o[$past(last)] == INSN_EBREAK); // R7
endmodule

// File: tb/sim_abs_reg_cmd_gen.sv
`timescale 1ns/1ps
module sim_abs_reg_cmd_gen;
  localparam int NH = 4, AW = 5;
  localparam logic [11:0] DB = 12'h380;
  localparam logic [31:0] EBRK = 32'h0010_0073;

  logic clk = 0, rst_ni = 0, cmd_valid = 0, transfer = 0, write = 0, postexec = 0;
  logic [2:0] size = 0;
  logic [15:0] regno = 0;
  logic [1:0] hartsel = 0;
  logic [4:0] pb = 0;
  logic [NH-1:0] done = 0;
  logic [AW-1:0][31:0] abuf, snap;
  logic [NH-1:0] go;
  logic [2:0] cmderr;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  abs_reg_cmd_gen u0 (
    .clk_i(clk), .rst_ni, .cmd_valid_i(cmd_valid), .transfer_i(transfer),
    .write_i(write), .postexec_i(postexec), .size_i(size), .regno_i(regno),
    .hartsel_i(hartsel), .progbuf_words_i(pb), .hart_done_i(done),
    .abs_buf_o(abuf), .go_o(go), .cmderr_o(cmderr)
  );

  function automatic logic [31:0] e_i(logic [11:0] imm, logic [4:0] rs1, logic [2:0] f3,
                                      logic [4:0] rd, logic [6:0] op);
    return (32'(imm) << 20) | (32'(rs1) << 15) | (32'(f3) << 12) | (32'(rd) << 7) | 32'(op);
  endfunction
  function automatic logic [31:0] e_s(logic [4:0] rs2, logic [2:0] f3, logic [6:0] op);
    return (32'(DB[11:5]) << 25) | (32'(rs2) << 20) | (32'(f3) << 12) | (32'(DB[4:0]) << 7) | 32'(op);
  endfunction
  function automatic logic [31:0] e_jal(int off);
    logic [20:0] o = 21'(off);
    return (32'(o[20]) << 31) | (32'(o[10:1]) << 21) | (32'(o[11]) << 20) |
           (32'(o[19:12]) << 12) | 32'h6f;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(logic t, logic w, logic p, logic [2:0] sz, logic [15:0] rn,
                       logic [1:0] h, logic [4:0] pbw);
    @(negedge clk);
    transfer = t; write = w; postexec = p; size = sz; regno = rn; hartsel = h; pb = pbw;
    cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic release_hart(int h);
    @(negedge clk); done[h] = 1;
    @(negedge clk); done = 0;
  endtask

  task automatic t_reset;
    chk("R1 go", 32'(go), 0);
    chk("R1 cmderr", 32'(cmderr), 0);
    for (int k = 0; k < AW; k++) chk("R1 buf", abuf[k], 0);
  endtask

  task automatic t_gpr;
    issue(1, 1, 0, 3'd2, 16'h1001, 2'd0, 5'd4);
    chk("R2 lw x1", abuf[0], e_i(DB, 0, 3'b010, 5'd1, 7'h03));
    chk("R7 ebreak idx1", abuf[1], EBRK);
    chk("R9 go hart0", 32'(go), 32'b0001);
    chk("R9 cmderr ok", 32'(cmderr), 0);
    release_hart(0);
    chk("R9 go cleared", 32'(go), 0);
    issue(1, 0, 1, 3'd3, 16'h101F, 2'd2, 5'd4);
    chk("R2 sd x31", abuf[0], e_s(5'd31, 3'b011, 7'h23));
    chk("R7 jal idx1", abuf[1], e_jal(4*AW - 4));
    chk("R9 go hart2", 32'(go), 32'b0100);
  endtask

  task automatic t_busy;
    snap = abuf;
    issue(1, 1, 0, 3'd2, 16'h1005, 2'd1, 5'd4);
    chk("R10 cmderr busy", 32'(cmderr), 1);
    chk("R10 go unchanged", 32'(go), 32'b0100);
    for (int k = 0; k < AW; k++) chk("R10 buf unchanged", abuf[k], snap[k]);
    release_hart(2);
    chk("R9 go cleared 2", 32'(go), 0);
  endtask

  task automatic t_fpr;
    issue(1, 1, 0, 3'd3, 16'h1020, 2'd3, 5'd4);
    chk("R3 fld f0", abuf[0], e_i(DB, 0, 3'b011, 5'd0, 7'h07));
    chk("R3 ebreak", abuf[1], EBRK);
    chk("R11 cmderr after busy", 32'(cmderr), 0);
    release_hart(3);
    issue(1, 0, 1, 3'd2, 16'h103F, 2'd3, 5'd4);
    chk("R3 fsw f31", abuf[0], e_s(5'd31, 3'b010, 7'h27));
    chk("R3 jal", abuf[1], e_jal(4*AW - 4));
    release_hart(3);
  endtask

  task automatic t_csr;
    issue(1, 1, 1, 3'd2, 16'h0300, 2'd1, 5'd0);
    chk("R4 w save", abuf[0], e_i(12'h7b2, 5'd8, 3'b001, 5'd0, 7'h73));
    chk("R4 w load s0", abuf[1], e_i(DB, 0, 3'b010, 5'd8, 7'h03));
    chk("R4 w csrw", abuf[2], e_i(12'h300, 5'd8, 3'b001, 5'd0, 7'h73));
    chk("R4 w restore", abuf[3], e_i(12'h7b2, 5'd0, 3'b010, 5'd8, 7'h73));
    chk("R7 jal idx4", abuf[4], e_jal(4*AW - 16));
    chk("R9 go hart1", 32'(go), 32'b0010);
    release_hart(1);
    issue(1, 0, 0, 3'd3, 16'h07b0, 2'd0, 5'd1);
    chk("R4 r save", abuf[0], e_i(12'h7b2, 5'd8, 3'b001, 5'd0, 7'h73));
    chk("R4 r csrr", abuf[1], e_i(12'h7b0, 5'd0, 3'b010, 5'd8, 7'h73));
    chk("R4 r sd s0", abuf[2], e_s(5'd8, 3'b011, 7'h23));
    chk("R4 r restore", abuf[3], e_i(12'h7b2, 5'd0, 3'b010, 5'd8, 7'h73));
    chk("R7 ebreak idx4", abuf[4], EBRK);
    release_hart(0);
  endtask

  task automatic t_notsup;
    snap = abuf;
    issue(1, 1, 0, 3'd2, 16'h0300, 2'd0, 5'd2);
    chk("R5 csr big pb err", 32'(cmderr), 2);
    chk("R5 csr big pb go", 32'(go), 0);
    issue(1, 0, 0, 3'd2, 16'h1040, 2'd0, 5'd4);
    chk("R5 high regno err", 32'(cmderr), 2);
    chk("R5 high regno go", 32'(go), 0);
    issue(1, 1, 0, 3'd1, 16'h1002, 2'd0, 5'd4);
    chk("R6 size1 err", 32'(cmderr), 2);
    issue(1, 1, 0, 3'd4, 16'h1002, 2'd0, 5'd4);
    chk("R6 size4 err", 32'(cmderr), 2);
    chk("R6 go", 32'(go), 0);
    for (int k = 0; k < AW; k++) chk("R5 buf unchanged", abuf[k], snap[k]);
  endtask

  task automatic t_notransfer;
    issue(0, 0, 1, 3'd0, 16'hFFFF, 2'd2, 5'd4);
    chk("R8 jal idx0", abuf[0], e_jal(4*AW));
    chk("R8 cmderr", 32'(cmderr), 0);
    chk("R8 go", 32'(go), 32'b0100);
    release_hart(2);
    issue(0, 1, 0, 3'd7, 16'h0001, 2'd1, 5'd9);
    chk("R8 ebreak idx0", abuf[0], EBRK);
    chk("R8 cmderr2", 32'(cmderr), 0);
    release_hart(1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_gpr();
    t_busy();
    t_fpr();
    t_csr();
    t_notsup();
    t_notransfer();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule